// File: doc/BRIEF.md
# Pixel Group Hit-Memory Controller

This block is the shared timestamp store for a group of sensor pixels. It sits in a column of dead pixels and serves 2N pixels, N on each side. Each pixel sends a raw comparator hit line. The controller synchronises that line and turns each rising edge into one write event. On that event it copies the running global timestamp into the next free register of that pixel and sets the hit flag for that register. Each pixel owns four registers, and they fill strictly in order.

A readout sequencer selects one pixel and one register and reads back the stored code and its flag on the same cycle. A clear strobe drops all flags and the overflow bit of the selected pixel, which frees the pixel for new hits. Hits that arrive while a pixel is full are dropped, and the pixel's overflow bit records the loss. A hit that lands on the same cycle as a clear of its pixel is kept and becomes the pixel's first entry.

Top module: `hitmem_ctrl`

## Requirements
- R1: After reset every hit flag reads 0 and every overflow bit (`ovf_o[p]` for pixel p) reads 0.
- R2: A rising edge on `hit_i[p]` causes exactly one write, however long the line stays high. A line that stays high causes no further write.
- R3: A pixel's registers fill in index order 0, 1, 2, 3, and each write sets the flag of the register it fills.
- R4: The stored code is the value of `ts_i` at the third rising clock edge after the hit line is first sampled high. The entry and its flag are readable after that edge, which is a capture latency of at most three clock cycles.
- R5: A hit on a pixel whose four registers are all flagged changes no register and no flag, and sets that pixel's overflow bit.
- R6: The read port is combinational. `rd_ts_o` and `rd_flag_o` show register `rd_reg_i` of pixel `rd_pix_i`, where pixels 0..N-1 lie on one side and N..2N-1 on the other.
- R7: A clock edge with `clr_i` high clears all flags and the overflow bit of pixel `rd_pix_i`. All other pixels are left unchanged.
- R8: A write event on a pixel at the same edge as a clear of that pixel is stored in register 0, with its flag set, after the clear.
- R9: Hits on several pixels in the same cycle are all stored, each in its own pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 2*N_SIDE | Raw comparator hit lines, one per pixel |
| ts_i | input | TS_W | Global timestamp code |
| rd_pix_i | input | $clog2(2*N_SIDE) | Pixel selected for readout and clear |
| rd_reg_i | input | $clog2(N_REG) | Register selected for readout |
| clr_i | input | 1 | Clears the selected pixel's flags and overflow bit |
| rd_ts_o | output | TS_W | Stored timestamp of the selected register |
| rd_flag_o | output | 1 | Hit flag of the selected register |
| ovf_o | output | 2*N_SIDE | Per-pixel overflow bits |

## Verification
The hardest case to reach from the ports is a clear that lands on the exact edge where a synchronised hit is written. The raw line has to rise two edges before the clear strobe is sampled, so the bench first fills a pixel until it overflows. It then raises that pixel's hit line and places the clear strobe with cycle-exact timing relative to the sync stages. Random rounds mix multi-pixel hits of random length with random clears. The timestamp changes while a hit is still held, which shows that the captured code belongs to the write edge.

// File: rtl/hm_pkg.sv
package hm_pkg;
  parameter int unsigned HM_SIDE_DEF = 8;
  parameter int unsigned HM_REGS_DEF = 4;
  parameter int unsigned HM_TS_W_DEF = 16;
endpackage

// File: rtl/hm_hit_sync.sv
module hm_hit_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse_o = s2_q & ~s3_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o & $past(pulse_o)) == '0); // R2
endmodule

// File: rtl/hm_slot.sv
module hm_slot #(
  parameter int unsigned N_REG = 4,
  parameter int unsigned TS_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hit_p,
  input  logic                        clr,
  input  logic [TS_W-1:0]             ts,
  output logic [N_REG-1:0][TS_W-1:0]  mem_o,
  output logic [N_REG-1:0]            flags_o,
  output logic                        ovf_o
);
  localparam int unsigned REG_W = $clog2(N_REG);
  localparam int unsigned CNT_W = $clog2(N_REG + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_REG);

  logic [CNT_W-1:0]           cnt_q, cnt_n;
  logic [N_REG-1:0]           flags_q, flags_n;
  logic                       ovf_q, ovf_n;
  logic [N_REG-1:0][TS_W-1:0] mem_q;
  logic                       wr_en;
  logic [REG_W-1:0]           wr_idx;

  always_comb begin
    cnt_n   = cnt_q;
    flags_n = flags_q;
    ovf_n   = ovf_q;
    wr_en   = 1'b0;
    wr_idx  = '0;
    if (clr) begin
      cnt_n   = '0;
      flags_n = '0;
      ovf_n   = 1'b0;
    end
    if (hit_p) begin
      if (clr) begin
        wr_en    = 1'b1;
        wr_idx   = '0;
        cnt_n    = CNT_W'(1);
        flags_n  = N_REG'(1);
      end else if (cnt_q < FULL) begin
        wr_en           = 1'b1;
        wr_idx          = cnt_q[REG_W-1:0];
        cnt_n           = cnt_q + CNT_W'(1);
        flags_n[wr_idx] = 1'b1;
      end else begin
        ovf_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flags_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      flags_q <= flags_n;
      ovf_q   <= ovf_n;
    end
  end

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (wr_en && (wr_idx == REG_W'(i))) begin
        mem_q[i] <= ts;
      end
    end
  end

  assign mem_o   = mem_q;
  assign flags_o = flags_q;
  assign ovf_o   = ovf_q;

  AST_ORDERED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & (flags_q + N_REG'(1))) == '0); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '1 && hit_p && !clr) |=> (ovf_q && $stable(mem_q) && $stable(flags_q))); // R5
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit_p) |=> (flags_q == '0 && !ovf_q)); // R7
  AST_CLR_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit_p) |=> (flags_q == N_REG'(1) && mem_q[0] == $past(ts))); // R8
endmodule

// File: rtl/hitmem_ctrl.sv
module hitmem_ctrl #(
  parameter int unsigned N_SIDE = hm_pkg::HM_SIDE_DEF,
  parameter int unsigned N_REG  = hm_pkg::HM_REGS_DEF,
  parameter int unsigned TS_W   = hm_pkg::HM_TS_W_DEF,
  localparam int unsigned NPIX  = 2 * N_SIDE,
  localparam int unsigned PIX_W = $clog2(NPIX),
  localparam int unsigned REG_W = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIX-1:0]  hit_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [PIX_W-1:0] rd_pix_i,
  input  logic [REG_W-1:0] rd_reg_i,
  input  logic             clr_i,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic             rd_flag_o,
  output logic [NPIX-1:0]  ovf_o
);
  logic [NPIX-1:0]            pulse;
  logic [N_REG-1:0][TS_W-1:0] mem   [NPIX];
  logic [N_REG-1:0]           flags [NPIX];

  hm_hit_sync #(.W(NPIX)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (hit_i),
    .pulse_o (pulse)
  );

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic clr_sel;
    assign clr_sel = clr_i && (rd_pix_i == PIX_W'(p));
    hm_slot #(.N_REG(N_REG), .TS_W(TS_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_p   (pulse[p]),
      .clr     (clr_sel),
      .ts      (ts_i),
      .mem_o   (mem[p]),
      .flags_o (flags[p]),
      .ovf_o   (ovf_o[p])
    );
  end

  always_comb begin
    rd_ts_o   = '0;
    rd_flag_o = 1'b0;
    for (int p = 0; p < NPIX; p++) begin
      if (rd_pix_i == PIX_W'(p)) begin
        rd_ts_o   = mem[p][rd_reg_i];
        rd_flag_o = flags[p][rd_reg_i];
      end
    end
  end

  AST_READ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !pulse[rd_pix_i]) |=> (!ovf_o[$past(rd_pix_i)])); // R7
endmodule

// File: tb/hitmem_ctrl_bench.sv
module hitmem_ctrl_bench;
  localparam int NS = 8, NR = 4, TW = 16, NP = 2 * NS;
  localparam int PW = $clog2(NP), RW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] hit_i = '0;
  logic [TW-1:0] ts_i = '0;
  logic [PW-1:0] rd_pix_i = '0;
  logic [RW-1:0] rd_reg_i = '0;
  logic          clr_i = 1'b0;
  logic [TW-1:0] rd_ts_o;
  logic          rd_flag_o;
  logic [NP-1:0] ovf_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int          exp_n   [NP];
  logic [TW-1:0] exp_ts [NP][NR];
  bit          exp_ovf [NP];

  hitmem_ctrl #(.N_SIDE(NS), .N_REG(NR), .TS_W(TW)) u_hitmem_ctrl (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_i(ts_i), .rd_pix_i(rd_pix_i),
    .rd_reg_i(rd_reg_i), .clr_i(clr_i), .rd_ts_o(rd_ts_o), .rd_flag_o(rd_flag_o),
    .ovf_o(ovf_o)
  );

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void model_hit(int p, logic [TW-1:0] t);
    if (exp_n[p] < NR) begin
      exp_ts[p][exp_n[p]] = t;
      exp_n[p]++;
    end else exp_ovf[p] = 1;
  endfunction

  function automatic void model_clr(int p);
    exp_n[p] = 0;
    exp_ovf[p] = 0;
  endfunction

  task automatic check_entry(int p, int r, string req);
    rd_pix_i = PW'(p);
    rd_reg_i = RW'(r);
    #1;
    chk(rd_flag_o == (r < exp_n[p]), req, rd_flag_o, r < exp_n[p]);
    if (r < exp_n[p]) chk(rd_ts_o == exp_ts[p][r], req, rd_ts_o, exp_ts[p][r]);
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++) check_entry(p, r, req);
      chk(ovf_o[p] == exp_ovf[p], "R5 overflow", ovf_o[p], exp_ovf[p]);
    end
  endtask

  // Raise lines in mask, capture ts at third edge, change ts while held.
  task automatic fire(logic [NP-1:0] mask, logic [TW-1:0] t, int hold);
    @(negedge clk);
    ts_i = t;
    hit_i = mask;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) if (mask[p]) model_hit(p, t);
    for (int p = 0; p < NP; p++)
      if (mask[p] && exp_n[p] > 0 && !exp_ovf[p]) check_entry(p, exp_n[p] - 1, "R4 latency");
    ts_i = t ^ 16'hA5A5;
    repeat (hold) @(negedge clk);
    hit_i = '0;
    repeat (3) @(negedge clk);
    sweep("R2 single write");
  endtask

  task automatic clear(int p);
    @(negedge clk);
    rd_pix_i = PW'(p);
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
    model_clr(p);
    sweep("R7 clear");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      exp_n[p] = 0;
      exp_ovf[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sweep("R1 reset");
    // R3 ordered fill on pixel 3 and R5 overflow
    for (int k = 0; k < NR + 1; k++) fire(NP'(1) << 3, TW'(16'h100 + k), 2);
    chk(ovf_o[3] == 1'b1, "R5", ovf_o[3], 1);
    // R8 hit coincident with clear
    @(negedge clk);
    ts_i = 16'hBEEF;
    hit_i = NP'(1) << 3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_pix_i = 3;
    clr_i = 1;
    @(posedge clk);
    @(negedge clk);
    clr_i = 0;
    hit_i = '0;
    model_clr(3);
    model_hit(3, 16'hBEEF);
    check_entry(3, 0, "R8 coincident");
    check_entry(3, 1, "R8 coincident");
    chk(ovf_o[3] == 1'b0, "R8 overflow cleared", ovf_o[3], 0);
    repeat (3) @(negedge clk);
    // R9 both sides at once, R6 read mapping
    fire({NP{1'b1}}, 16'h7777, 1);
    fire(NP'(1) | (NP'(1) << (NP - 1)), 16'h0001, 4);
    // random rounds
    void'($urandom(32'd1234));
    for (int it = 0; it < 150; it++) begin
      if (($urandom % 4) == 0) clear(int'($urandom % NP));
      else fire(NP'($urandom) & NP'($urandom), TW'($urandom), 1 + int'($urandom % 4));
    end
    sweep("R6 final read");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule